// File: doc/BRIEF.md
# Floating-Point Exception Accumulate-and-Trap Unit

This block sits after a floating-point execution pipe. For each completed operation it receives the exception flags the operation raised and folds them into a sticky status register. In the same step it decides whether the operation must request an arithmetic trap. When it asks for a trap, it also presents a summary word for the handler and a one-hot mask that names the destination register of the faulting operation.

Two trap policies are selected per operation by a software-completion bit. In the plain policy, every raised flag is recorded in the status register. Any flag not covered by the ignore mask then causes a trap. In the software-completion policy, ignored flags are dropped before anything is recorded. The trap decision then depends on the privilege mode. In system mode, any surviving flag traps. In user mode, a trap is raised only when some surviving flag is also enabled. On this path the summary carries an extra marker bit.

The status register can also be loaded by a direct write port. One decision is made per valid input, and its outputs are registered one clock later.

Top module: `fp_exc_trap_unit`

Flag vector bit order, shared by all 6-bit inputs and by the status register: bit 0 invalid, bit 1 divide-by-zero, bit 2 overflow, bit 3 underflow, bit 4 inexact, bit 5 integer overflow.

## Requirements
- R1: While `rst` is high at a clock edge, `status`, `trap_req`, `summary` and `reg_mask` all become zero.
- R2: With `swc_mode` low and `in_valid` high, every bit of `exc_flags` is ORed into `status`, whatever `ignore_mask` says.
- R3: With `swc_mode` low, a trap is requested when `exc_flags & ~ignore_mask` is nonzero, in either privilege mode. The summary then holds those surviving flags in bits 6:1 (same order as the flag vector) and 0 in bit 0.
- R4: With `swc_mode` high, only `exc_flags & ~ignore_mask` is ORed into `status`.
- R5: With `swc_mode` high and `user_mode` low, a trap is requested when `exc_flags & ~ignore_mask` is nonzero. The summary holds `exc_flags & ~ignore_mask & enable_mask` in bits 6:1 and 1 in bit 0.
- R6: With `swc_mode` high and `user_mode` high, a trap is requested only when `exc_flags & ~ignore_mask & enable_mask` is nonzero. The summary is formed as in R5.
- R7: When a trap is requested, `reg_mask` equals 1 shifted left by `dest_reg`, which is a one-hot value.
- R8: A zero `exc_flags` vector leaves `status` unchanged and requests no trap. Inputs presented with `in_valid` low have no effect on any output.
- R9: A high `wr_en` loads `wr_data` into `status`. Flags merged in the same cycle are ORed onto the written value.
- R10: `trap_req` is high for exactly the one cycle after the triggering valid input. `summary` and `reg_mask` change only in a cycle where `trap_req` is high, and otherwise hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | An operation's flags are presented this cycle |
| exc_flags | input | 6 | Exception flags raised by the operation |
| ignore_mask | input | 6 | Flags the operation wants ignored |
| enable_mask | input | 6 | Trap enables used on the software-completion path |
| swc_mode | input | 1 | Selects the software-completion policy |
| user_mode | input | 1 | High in user mode, low in system mode |
| dest_reg | input | 6 | Destination register number of the operation |
| wr_en | input | 1 | Direct write of the status register |
| wr_data | input | 6 | Value for the direct write |
| status | output | 6 | Sticky accumulated exception flags |
| trap_req | output | 1 | One-cycle trap request |
| summary | output | 7 | Bit 0 software-completion marker, bits 6:1 trapping flags |
| reg_mask | output | 64 | One-hot destination register mask |

## Verification
The bench sweeps every 6-bit flag vector against a spread of ignore and enable masks, under all four combinations of policy and privilege mode.

A design that applied the ignore mask before recording flags in the plain policy would lose ignored flags from `status`. Applying it after recording on the software-completion path would leak ignored flags in. A design that filtered by the enable mask in system mode, or skipped that filter in user mode, would show a wrong `trap_req` in exactly those sweeps.

Alternate operations also write the status register in the same cycle as a merge, which catches a write that overrides the merge. Idle cycles drive garbage flags with `in_valid` low, which exposes a trap pulse that lasts too long or an output that moves without a trap.

// File: rtl/fp_exc_trap_unit.sv
module fp_exc_trap_unit #(
  parameter int NFLAG = 6,
  parameter int REG_IDX_W = 6,
  localparam int NREG = 1 << REG_IDX_W,
  localparam int SUM_W = NFLAG + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [NFLAG-1:0]     exc_flags,
  input  logic [NFLAG-1:0]     ignore_mask,
  input  logic [NFLAG-1:0]     enable_mask,
  input  logic                 swc_mode,
  input  logic                 user_mode,
  input  logic [REG_IDX_W-1:0] dest_reg,
  input  logic                 wr_en,
  input  logic [NFLAG-1:0]     wr_data,
  output logic [NFLAG-1:0]     status,
  output logic                 trap_req,
  output logic [SUM_W-1:0]     summary,
  output logic [NREG-1:0]      reg_mask
);

  logic [NFLAG-1:0] kept, kept_en, merge_bits, trap_bits, status_base;
  logic             trap_now;

  assign kept       = exc_flags & ~ignore_mask;
  assign kept_en    = kept & enable_mask;
  assign merge_bits = in_valid ? (swc_mode ? kept : exc_flags) : '0;
  assign trap_bits  = swc_mode ? kept_en : kept;
  assign trap_now   = in_valid & (swc_mode ? (user_mode ? |kept_en : |kept) : |kept);
  assign status_base = wr_en ? wr_data : status;

  always_ff @(posedge clk) begin
    if (rst) begin
      status   <= '0;
      trap_req <= 1'b0;
      summary  <= '0;
      reg_mask <= '0;
    end else begin
      status   <= status_base | merge_bits;
      trap_req <= trap_now;
      if (trap_now) begin
        summary  <= {trap_bits, swc_mode};
        reg_mask <= {{(NREG-1){1'b0}}, 1'b1} << dest_reg;
      end
    end
  end

  assert_sticky_R2 : assert property (@(posedge clk) disable iff (rst)
    !$past(wr_en) |-> ((status & $past(status)) == $past(status)));

  assert_trap_from_valid_R10 : assert property (@(posedge clk) disable iff (rst)
    trap_req |-> ($past(in_valid) && $past(exc_flags) != '0));

  assert_hold_R10 : assert property (@(posedge clk) disable iff (rst)
    !trap_req |-> ($stable(summary) && $stable(reg_mask)));

  assert_onehot_R7 : assert property (@(posedge clk) disable iff (rst)
    trap_req |-> ($countones(reg_mask) == 1 && reg_mask[$past(dest_reg)]));

  assert_swc_marker_R5 : assert property (@(posedge clk) disable iff (rst)
    trap_req |-> (summary[0] == $past(swc_mode)));

  assert_pulse_R10 : assert property (@(posedge clk) disable iff (rst)
    trap_req |=> (!trap_req || $past(in_valid)));

endmodule

// File: tb/fp_exc_trap_unit_tb.sv
`timescale 1ns/1ps
module fp_exc_trap_unit_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst, in_valid, swc_mode, user_mode, wr_en;
  logic [5:0]  exc_flags, ignore_mask, enable_mask, dest_reg, wr_data;
  logic [5:0]  status;
  logic        trap_req;
  logic [6:0]  summary;
  logic [63:0] reg_mask;

  fp_exc_trap_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .exc_flags(exc_flags),
    .ignore_mask(ignore_mask), .enable_mask(enable_mask), .swc_mode(swc_mode),
    .user_mode(user_mode), .dest_reg(dest_reg), .wr_en(wr_en), .wr_data(wr_data),
    .status(status), .trap_req(trap_req), .summary(summary), .reg_mask(reg_mask)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    logic [5:0]  st, surv, en_b, merge, tflags;
    logic [6:0]  es;
    logic [63:0] em;
    logic        trap;
    rst = 1; in_valid = 0; exc_flags = 0; ignore_mask = 0; enable_mask = 0;
    swc_mode = 0; user_mode = 0; dest_reg = 0; wr_en = 0; wr_data = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 status", status, 0);
    chk("R1 trap_req", trap_req, 0);
    chk("R1 summary", summary, 0);
    chk("R1 reg_mask", reg_mask, 0);
    rst = 0;
    st = 0; es = 0; em = 0;
    for (int m = 0; m < 4; m++) begin
      for (int f = 0; f < 64; f++) begin
        for (int ig = 0; ig < 8; ig++) begin
          string rs, rt;
          in_valid    = 1;
          exc_flags   = 6'(f);
          ignore_mask = (ig == 0) ? 6'd0 : 6'((ig * 37) & 63);
          enable_mask = 6'((f * 5 + ig * 11) & 63);
          swc_mode    = m[1];
          user_mode   = m[0];
          dest_reg    = 6'((f + ig * 7) & 63);
          wr_en       = ig[0];
          wr_data     = 6'((f * 3 + ig) & 63);
          surv  = exc_flags & ~ignore_mask;
          en_b  = surv & enable_mask;
          merge = swc_mode ? surv : exc_flags;
          if (!swc_mode) begin trap = (surv != 0); tflags = surv; end
          else begin trap = user_mode ? (en_b != 0) : (surv != 0); tflags = en_b; end
          st = (wr_en ? wr_data : st) | merge;
          if (trap) begin es = {tflags, swc_mode}; em = 64'd1 << dest_reg; end
          rs = (f == 0) ? "R8" : (wr_en ? "R9" : (swc_mode ? "R4" : "R2"));
          rt = (f == 0) ? "R8" : (!swc_mode ? "R3" : (user_mode ? "R6" : "R5"));
          @(negedge clk);
          chk({rs, " status"}, status, st);
          chk({rt, " trap_req"}, trap_req, trap);
          chk({rt, " summary"}, summary, es);
          chk("R7 reg_mask", reg_mask, em);
          in_valid  = 0;
          wr_en     = 0;
          exc_flags = ~6'(f);
          ignore_mask = 0;
          @(negedge clk);
          chk("R10 trap_req pulse", trap_req, 0);
          chk("R8 status idle", status, st);
          chk("R10 summary hold", summary, es);
          chk("R10 reg_mask hold", reg_mask, em);
        end
      end
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule